// File: doc/BRIEF.md
# Two-Thread Command Scheduler with Credits

This block sits between an upstream interconnect port and the command queue of a downstream memory controller. It accepts commands from two traffic classes, a high-priority thread and a low-priority thread. Each class has its own ready/valid handshake and its own in-order queue of eight entries. Every cycle it offers one command downstream. The high thread wins whenever its head command is free to go, so commands from the two threads can leave in a different order from the one in which they arrived.

Cross-thread ordering is kept only where addresses collide. A high-priority command that touches the same 64-byte block as a low-priority command accepted before it is held back until that low-priority command has issued. The hold then lifts without further action. Apart from such a dependency, the high thread keeps moving even when the low thread cannot be accepted at all.

Admission is paced by credits. The block keeps a shared (global) pool and a pool reserved for the high thread, both loaded from parameters at reset. The high thread draws on the reserved pool first. The low thread can use only the shared pool. A reserved credit comes back as soon as its command issues. A shared credit waits until the downstream queue reports more free slots than a programmable 5-bit critical threshold.

Top module: `dual_thread_sched`

## Requirements
- R1: After reset, no command is offered (`issValid`=0), both `hiReady` and `loReady` are 1, and neither credit-return pulse is asserted.
- R2: When the high queue head is eligible, it is offered (`issThread`=1, meaning high; 0 means low) even if the low queue is not empty.
- R3: Within each thread, commands are offered downstream in exactly the order they were accepted, and a command leaves only on a cycle with `issValid` and `issReady` both high.
- R4: A high head whose block matches a low command accepted in an earlier cycle, and still queued, is not offered. The low commands are offered first, and the high head becomes eligible in the cycle after its last blocker issues.
- R5: With the shared pool empty, `loReady` is 0 while `hiReady` stays 1 as long as reserved credits remain and the high queue is not full.
- R6: An accepted high command takes a reserved credit if one is available, otherwise a shared one. A low command needs a shared credit. If one shared credit is left and a high command takes it in a cycle, `loReady` is 0 in that cycle.
- R7: `globCreditRet` pulses for one returned shared credit per cycle only while shared credits owed by issued commands are pending and `dsFree` is strictly greater than `critThresh` (0..31). When `dsFree` equals the threshold, no credit is returned.
- R8: `hiCreditRet` is asserted in the same cycle that a high command holding a reserved credit issues, whatever `dsFree` is, and that credit can be used again from the next cycle.
- R9: The conflict test compares address bits 31..6 only: addresses differing only in bits 5..0 conflict, and addresses differing in bit 6 or above do not.
- R10: A low command accepted in the same cycle as, or after, a high command never holds that high command back.
- R11: A thread's ready is 0 while its queue holds 8 commands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| critThresh | input | 5 | Critical threshold for shared credit return |
| dsFree | input | 6 | Free slots in the downstream command queue |
| hiValid | input | 1 | High-thread command valid |
| hiReady | output | 1 | High-thread command accepted when valid |
| hiAddr | input | 32 | High-thread command address |
| loValid | input | 1 | Low-thread command valid |
| loReady | output | 1 | Low-thread command accepted when valid |
| loAddr | input | 32 | Low-thread command address |
| issValid | output | 1 | A command is offered downstream |
| issReady | input | 1 | Downstream takes the offered command |
| issThread | output | 1 | Thread of the offered command, 1 = high |
| issAddr | output | 32 | Address of the offered command |
| globCreditRet | output | 1 | One shared credit returned upstream this cycle |
| hiCreditRet | output | 1 | One reserved credit returned upstream this cycle |

## Verification
All outputs are combinational functions of registered state and the current inputs. An offer, a ready or a return pulse is therefore due in the same cycle as the stimulus that causes it. A command accepted at an edge can be offered in the cycle after that edge, and a returned credit can be reused one edge after its pulse. The bench drives inputs just after the falling edge and compares outputs one nanosecond later. At that point it has a model state that it updates only after the comparison, so every check sees exactly the state committed at the previous rising edge.

// File: rtl/dts_pkg.sv
package dts_pkg;
  typedef struct packed {
    logic hiPush;
    logic loPush;
    logic hiPop;
    logic loPop;
    logic hiUseRes;
    logic selHi;
  } dtsStrobe_t;
endpackage

// File: rtl/dts_ring.sv
module dts_ring #(
  parameter int W     = 32,
  parameter int DEPTH = 8,
  parameter int PW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             push,
  input  logic             pop,
  input  logic [W-1:0]     wrData,
  output logic [W-1:0]     rdData,
  output logic             full,
  output logic             empty,
  output logic [PW-1:0]    wrPtr,
  output logic [PW-1:0]    rdPtr,
  output logic [DEPTH-1:0] occ
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

  logic [W-1:0]     mem [DEPTH];
  logic [CW-1:0]    count;
  logic [DEPTH-1:0] pushMask;
  logic [DEPTH-1:0] popMask;

  assign pushMask = push ? (DEPTH'(1) << wrPtr) : '0;
  assign popMask  = pop  ? (DEPTH'(1) << rdPtr) : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
      occ   <= '0;
    end else begin
      if (push) wrPtr <= (wrPtr == LAST) ? '0 : wrPtr + 1'b1;
      if (pop)  rdPtr <= (rdPtr == LAST) ? '0 : rdPtr + 1'b1;
      count <= count + CW'(push) - CW'(pop);
      occ   <= (occ & ~popMask) | pushMask;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wrPtr] <= wrData;
  end

  assign rdData = mem[rdPtr];
  assign full   = (count == CW'(DEPTH));
  assign empty  = (count == '0);

  AST_NO_OVERFLOW:  assert property (@(posedge clk) disable iff (!rstN) push |-> !full); // R11
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rstN) pop |-> !empty); // R3
  AST_OCC_COUNT:    assert property (@(posedge clk) disable iff (!rstN) $countones(occ) == int'(count)); // R3
endmodule

// File: rtl/dts_datapath.sv
module dts_datapath import dts_pkg::*; #(
  parameter int ADDR_W  = 32,
  parameter int DEPTH   = 8,
  parameter int BLK_LSB = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  dtsStrobe_t        stb,
  input  logic [ADDR_W-1:0] hiAddr,
  input  logic [ADDR_W-1:0] loAddr,
  output logic [ADDR_W-1:0] issAddr,
  output logic              hiFull,
  output logic              hiEmpty,
  output logic              loFull,
  output logic              loEmpty,
  output logic              hiHeadBlocked,
  output logic              hiHeadUseRes
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int TW = ADDR_W - BLK_LSB;

  logic [ADDR_W:0]   hiHead;
  logic [ADDR_W-1:0] loHead;
  logic [PW-1:0]     hiWr, hiRd, loWr, loRd;
  logic [DEPTH-1:0]  hiOcc, loOcc;
  logic [DEPTH-1:0]  loClr;
  logic [DEPTH-1:0]  newMask;
  logic [DEPTH-1:0]  blockMask [DEPTH];
  logic [TW-1:0]     loTag [DEPTH];

  dts_ring #(.W(ADDR_W + 1), .DEPTH(DEPTH), .PW(PW)) uHiQ (
    .clk(clk), .rstN(rstN), .push(stb.hiPush), .pop(stb.hiPop),
    .wrData({stb.hiUseRes, hiAddr}), .rdData(hiHead),
    .full(hiFull), .empty(hiEmpty), .wrPtr(hiWr), .rdPtr(hiRd), .occ(hiOcc)
  );

  dts_ring #(.W(ADDR_W), .DEPTH(DEPTH), .PW(PW)) uLoQ (
    .clk(clk), .rstN(rstN), .push(stb.loPush), .pop(stb.loPop),
    .wrData(loAddr), .rdData(loHead),
    .full(loFull), .empty(loEmpty), .wrPtr(loWr), .rdPtr(loRd), .occ(loOcc)
  );

  // Block tag of every low slot, kept for the conflict compare
  always_ff @(posedge clk) begin
    if (stb.loPush) loTag[loWr] <= loAddr[ADDR_W-1:BLK_LSB];
  end

  assign loClr = stb.loPop ? (DEPTH'(1) << loRd) : '0;

  // Dependencies of an arriving high command: queued low slots in its block,
  // minus the one leaving this cycle
  for (genvar j = 0; j < DEPTH; j++) begin : gConflict
    assign newMask[j] = loOcc[j] && !loClr[j] &&
                        (loTag[j] == hiAddr[ADDR_W-1:BLK_LSB]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) blockMask[i] <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (stb.hiPush && hiWr == PW'(i)) blockMask[i] <= newMask;
        else                              blockMask[i] <= blockMask[i] & ~loClr;
      end
    end
  end

  assign hiHeadBlocked = hiOcc[hiRd] && (|blockMask[hiRd]);
  assign hiHeadUseRes  = hiHead[ADDR_W];
  assign issAddr       = stb.selHi ? hiHead[ADDR_W-1:0] : loHead;

  AST_HI_WAITS_LO: assert property (@(posedge clk) disable iff (!rstN)
    stb.hiPop |-> !hiHeadBlocked); // R4
  AST_BLOCKERS_QUEUED: assert property (@(posedge clk) disable iff (!rstN)
    hiOcc[hiRd] |-> ((blockMask[hiRd] & ~loOcc) == '0)); // R4
endmodule

// File: rtl/dts_control.sv
module dts_control import dts_pkg::*; #(
  parameter int GLOB_CRED = 8,
  parameter int HI_CRED   = 2,
  parameter int FREE_W    = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hiValid,
  input  logic              loValid,
  input  logic              issReady,
  input  logic [FREE_W-1:0] dsFree,
  input  logic [4:0]        critThresh,
  input  logic              hiFull,
  input  logic              hiEmpty,
  input  logic              loFull,
  input  logic              loEmpty,
  input  logic              hiHeadBlocked,
  input  logic              hiHeadUseRes,
  output dtsStrobe_t        stb,
  output logic              hiReady,
  output logic              loReady,
  output logic              issValid,
  output logic              globCreditRet,
  output logic              hiCreditRet
);
  localparam int GW = $clog2(GLOB_CRED + 2);
  localparam int HW = $clog2(HI_CRED + 2);

  logic [GW-1:0] gAvail, gPend;
  logic [HW-1:0] hAvail;
  logic hiElig, fire, hiTakesGlob, gRelease, hiPushGlob;

  assign hiElig      = !hiEmpty && !hiHeadBlocked;
  assign issValid    = hiElig || !loEmpty;
  assign fire        = issValid && issReady;

  assign hiReady     = !hiFull && (hAvail != '0 || gAvail != '0);
  assign hiTakesGlob = hiValid && hiReady && (hAvail == '0);
  assign loReady     = !loFull && (32'(gAvail) > (hiTakesGlob ? 32'd1 : 32'd0));

  always_comb begin
    stb          = '0;
    stb.selHi    = hiElig;
    stb.hiPop    = fire && hiElig;
    stb.loPop    = fire && !hiElig;
    stb.hiPush   = hiValid && hiReady;
    stb.loPush   = loValid && loReady;
    stb.hiUseRes = (hAvail != '0);
  end

  assign globCreditRet = (gPend != '0) && (32'(dsFree) > 32'(critThresh));
  assign hiCreditRet   = stb.hiPop && hiHeadUseRes;
  assign gRelease      = (stb.hiPop && !hiHeadUseRes) || stb.loPop;
  assign hiPushGlob    = stb.hiPush && !stb.hiUseRes;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gAvail <= GW'(GLOB_CRED);
      hAvail <= HW'(HI_CRED);
      gPend  <= '0;
    end else begin
      gAvail <= gAvail - GW'(hiPushGlob) - GW'(stb.loPush) + GW'(globCreditRet);
      hAvail <= hAvail - HW'(stb.hiPush && stb.hiUseRes) + HW'(hiCreditRet);
      gPend  <= gPend + GW'(gRelease) - GW'(globCreditRet);
    end
  end

  AST_RES_BOUND:  assert property (@(posedge clk) disable iff (!rstN)
    32'(hAvail) <= HI_CRED); // R8
  AST_GLOB_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    (32'(gAvail) + 32'(gPend)) <= GLOB_CRED); // R7
  AST_GLOB_RET_PEND: assert property (@(posedge clk) disable iff (!rstN)
    globCreditRet |=> (gAvail != '0)); // R7
endmodule

// File: rtl/dual_thread_sched.sv
module dual_thread_sched import dts_pkg::*; #(
  parameter int ADDR_W    = 32,
  parameter int DEPTH     = 8,
  parameter int BLK_LSB   = 6,
  parameter int GLOB_CRED = 8,
  parameter int HI_CRED   = 2,
  parameter int FREE_W    = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [4:0]        critThresh,
  input  logic [FREE_W-1:0] dsFree,
  input  logic              hiValid,
  output logic              hiReady,
  input  logic [ADDR_W-1:0] hiAddr,
  input  logic              loValid,
  output logic              loReady,
  input  logic [ADDR_W-1:0] loAddr,
  output logic              issValid,
  input  logic              issReady,
  output logic              issThread,
  output logic [ADDR_W-1:0] issAddr,
  output logic              globCreditRet,
  output logic              hiCreditRet
);
  dtsStrobe_t stb;
  logic hiFull, hiEmpty, loFull, loEmpty, hiHeadBlocked, hiHeadUseRes;

  dts_control #(.GLOB_CRED(GLOB_CRED), .HI_CRED(HI_CRED), .FREE_W(FREE_W)) uCtl (
    .clk(clk), .rstN(rstN), .hiValid(hiValid), .loValid(loValid),
    .issReady(issReady), .dsFree(dsFree), .critThresh(critThresh),
    .hiFull(hiFull), .hiEmpty(hiEmpty), .loFull(loFull), .loEmpty(loEmpty),
    .hiHeadBlocked(hiHeadBlocked), .hiHeadUseRes(hiHeadUseRes),
    .stb(stb), .hiReady(hiReady), .loReady(loReady), .issValid(issValid),
    .globCreditRet(globCreditRet), .hiCreditRet(hiCreditRet)
  );

  dts_datapath #(.ADDR_W(ADDR_W), .DEPTH(DEPTH), .BLK_LSB(BLK_LSB)) uDp (
    .clk(clk), .rstN(rstN), .stb(stb), .hiAddr(hiAddr), .loAddr(loAddr),
    .issAddr(issAddr), .hiFull(hiFull), .hiEmpty(hiEmpty),
    .loFull(loFull), .loEmpty(loEmpty),
    .hiHeadBlocked(hiHeadBlocked), .hiHeadUseRes(hiHeadUseRes)
  );

  assign issThread = stb.selHi;

  AST_HI_FIRST: assert property (@(posedge clk) disable iff (!rstN)
    (issValid && !issThread) |-> (hiEmpty || hiHeadBlocked)); // R2
endmodule

// File: tb/dual_thread_sched_test.sv
`timescale 1ns/1ps
module dual_thread_sched_test;
  localparam int DEPTH = 8;
  localparam int GLOB  = 8;
  localparam int HRES  = 2;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [4:0]  critThresh = '0;
  logic [5:0]  dsFree = '0;
  logic        hiValid = 1'b0, loValid = 1'b0, issReady = 1'b0;
  logic [31:0] hiAddr = '0, loAddr = '0;
  logic        hiReady, loReady, issValid, issThread, globCreditRet, hiCreditRet;
  logic [31:0] issAddr;

  always #2.5 clk = ~clk;

  dual_thread_sched uut (
    .clk(clk), .rstN(rstN), .critThresh(critThresh), .dsFree(dsFree),
    .hiValid(hiValid), .hiReady(hiReady), .hiAddr(hiAddr),
    .loValid(loValid), .loReady(loReady), .loAddr(loAddr),
    .issValid(issValid), .issReady(issReady), .issThread(issThread),
    .issAddr(issAddr), .globCreditRet(globCreditRet), .hiCreditRet(hiCreditRet)
  );

  typedef struct {
    logic [31:0] addr;
    bit          res;
    int          seq;
  } ent_t;

  ent_t hiQ[$];
  ent_t loQ[$];
  int mG, mH, mPend, seqCnt;
  int nChecks = 0, nFails = 0;
  bit finished = 0;

  function automatic logic [25:0] blk(logic [31:0] a);
    return a[31:6];
  endfunction

  // R4 R9 R10: high head waits only for earlier low commands in its block
  function automatic bit headBlocked();
    if (hiQ.size() == 0) return 0;
    foreach (loQ[k])
      if (loQ[k].seq < hiQ[0].seq && blk(loQ[k].addr) == blk(hiQ[0].addr)) return 1;
    return 0;
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step(bit hv, logic [31:0] ha, bit lv, logic [31:0] la,
                      bit ir, int df, int ct);
    bit eBlk, eHiElig, eIssV, eHiR, eHiG, eLoR, eGR, fire, eHR, eUse;
    @(negedge clk);
    hiValid = hv; hiAddr = ha; loValid = lv; loAddr = la;
    issReady = ir; dsFree = 6'(df); critThresh = 5'(ct);
    #1;
    eBlk    = headBlocked();
    eHiElig = (hiQ.size() > 0) && !eBlk;
    eIssV   = eHiElig || (loQ.size() > 0);
    eHiR    = (hiQ.size() < DEPTH) && (mH > 0 || mG > 0);
    eHiG    = hv && eHiR && (mH == 0);
    eLoR    = (loQ.size() < DEPTH) && (mG > (eHiG ? 1 : 0));
    eGR     = (mPend > 0) && (df > ct);
    fire    = eIssV && ir;
    eHR     = fire && eHiElig && hiQ[0].res;
    eUse    = (mH > 0);
    chk("R5 R6 R11 hiReady", 64'(hiReady), 64'(eHiR));
    chk("R5 R6 R11 loReady", 64'(loReady), 64'(eLoR));
    chk("R2 R4 issValid", 64'(issValid), 64'(eIssV));
    if (eIssV) begin
      chk("R2 R4 R10 issThread", 64'(issThread), 64'(eHiElig));
      chk("R3 R9 issAddr", 64'(issAddr), 64'(eHiElig ? hiQ[0].addr : loQ[0].addr));
    end
    chk("R7 globCreditRet", 64'(globCreditRet), 64'(eGR));
    chk("R8 hiCreditRet", 64'(hiCreditRet), 64'(eHR));
    // model update, mirrors the edge that follows
    if (fire) begin
      if (eHiElig) begin
        if (hiQ[0].res) mH++; else mPend++;
        void'(hiQ.pop_front());
      end else begin
        mPend++;
        void'(loQ.pop_front());
      end
    end
    if (eGR) begin mPend--; mG++; end
    if (hv && eHiR) begin
      if (eUse) mH--; else mG--;
      hiQ.push_back('{addr: ha, res: eUse, seq: seqCnt});
      seqCnt++;
    end
    if (lv && eLoR) begin
      mG--;
      loQ.push_back('{addr: la, res: 1'b0, seq: seqCnt});
      seqCnt++;
    end
  endtask

  task automatic idle(int n, bit ir, int df, int ct);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, ir, df, ct);
  endtask

  function automatic logic [31:0] rndAddr();
    logic [31:0] r;
    r = $urandom;
    return {24'h000010, r[7:0]};   // four blocks, random offsets: many conflicts
  endfunction

  initial begin
    void'($urandom(32'd20240611));
    mG = GLOB; mH = HRES; mPend = 0; seqCnt = 0;
    repeat (4) @(posedge clk);
    rstN = 1'b1;
    @(negedge clk); #1;
    // R1: reset state
    chk("R1 issValid", 64'(issValid), 64'd0);
    chk("R1 hiReady", 64'(hiReady), 64'd1);
    chk("R1 loReady", 64'(loReady), 64'd1);
    chk("R1 globCreditRet", 64'(globCreditRet), 64'd0);
    chk("R1 hiCreditRet", 64'(hiCreditRet), 64'd0);

    // R4 R9: same 64-byte block, low first, high must wait
    step(0, 0, 1, 32'h1000, 0, 0, 0);
    step(1, 32'h1020, 0, 0, 0, 0, 0);
    // R9: different block (bit 6 differs), high overtakes
    step(0, 0, 1, 32'h3000, 0, 0, 0);
    step(1, 32'h3040, 0, 0, 0, 0, 0);
    // R10: low accepted in same cycle as high in same block does not block
    step(1, 32'h2010, 1, 32'h2000, 0, 0, 0);
    idle(8, 1, 0, 0);

    // R7: pending shared credits, threshold boundaries
    idle(2, 1, 5, 5);
    idle(2, 1, 6, 5);
    idle(2, 1, 31, 31);
    idle(2, 1, 32, 31);
    idle(4, 1, 63, 0);

    // R5 R6 R11: exhaust shared credits with low traffic, high uses reserved
    for (int i = 0; i < 10; i++) step(0, 0, 1, 32'h4000 + 32'(i * 64), 0, 0, 0);
    for (int i = 0; i < 4; i++)  step(1, 32'h8000 + 32'(i * 64), 0, 0, 0, 0, 0);
    idle(20, 1, 0, 0);          // R8: reserved returns without threshold
    idle(12, 1, 63, 3);
    // R11: fill high queue to eight
    for (int i = 0; i < 10; i++) step(1, 32'h9000 + 32'(i * 64), 0, 0, 0, 63, 0);
    idle(16, 1, 63, 0);

    // R6: one shared credit left, high and low both valid in the same cycle
    for (int i = 0; i < 7; i++) step(0, 0, 1, 32'h5000 + 32'(i * 64), 0, 0, 0);
    step(1, 32'h6000, 0, 0, 0, 0, 0);
    step(1, 32'h6040, 0, 0, 0, 0, 0);
    step(1, 32'h6080, 1, 32'h7000, 0, 0, 0);
    idle(20, 1, 63, 0);

    // Constrained random phase (R2 R3 R4 R7 R8)
    for (int i = 0; i < 4000; i++) begin
      int sel, df, ct;
      sel = int'($urandom % 100);
      ct  = (i / 250) % 3 == 0 ? 31 : int'($urandom % 12);
      df  = int'($urandom % 40);
      step(sel < 45, rndAddr(), (sel % 3) != 0, rndAddr(),
           ((i / 300) % 4 == 1) ? (sel < 10) : (sel < 70), df, ct);
    end
    idle(40, 1, 63, 0);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nFails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end
endmodule